// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block forms the effective memory address for a single instruction step of a register-based processor whose memory is split into regions. Each step supplies a set of decoded flags, a signed immediate and the current values of four registers: the low word of a general data register, the return register, the stack pointer and the context index. The block picks a base value, adds the terms that the flags enable, and registers the result on the next rising clock edge.

The address is a 32-bit value and all arithmetic wraps modulo 2^32. The base starts at zero. The data-register word can replace it, and the return register can replace it with higher priority. The immediate is sign-extended and added. A stack access adds the stack pointer and a fixed stack region offset. A context access adds the context index scaled by a fixed per-context stride. A memory access adds a fixed memory region offset. A strobe marks the registered address as belonging to a step that carried the memory-operation flag.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `addr_o` becomes 0 and `addr_vld_o` becomes 0 on that edge, whatever the other inputs are.
- R2: `addr_vld_o` is 1 in the cycle after a step with `mop_i`=1 and 0 in the cycle after a step with `mop_i`=0.
- R3: With `sel_e0_i`, `sel_ret_i`, `stk_i`, `ctx_en_i` and `mem_i` all 0 and `imm_i`=0, the registered address is 0.
- R4: With `sel_e0_i`=1 and `sel_ret_i`=0, the base of the sum is `e0_i`.
- R5: With `sel_ret_i`=1, the base is `ret_i` whether or not `sel_e0_i` is set.
- R6: `imm_i` is a 16-bit two's-complement value; it is sign-extended to 32 bits and added to the base.
- R7: With `stk_i`=1, both `sp_i` and the stack region offset 0x10000 are added.
- R8: With `ctx_en_i`=1, `ctx_i` multiplied by 0x40000 (truncated to 32 bits) is added.
- R9: With `mem_i`=1, the memory region offset 0x20000 is added; when `stk_i` and `mem_i` are both 1, both region offsets are added and nothing is flagged.
- R10: The sum of all enabled terms wraps modulo 2^32, and `addr_o` shows it one clock after the step is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mop_i | input | 1 | Step performs a memory operation |
| sel_e0_i | input | 1 | Use data-register low word as base |
| sel_ret_i | input | 1 | Use return register as base (priority) |
| stk_i | input | 1 | Add stack pointer and stack region offset |
| ctx_en_i | input | 1 | Add scaled context index |
| mem_i | input | 1 | Add memory region offset |
| imm_i | input | 16 | Signed immediate offset |
| e0_i | input | 32 | Data-register low word |
| ret_i | input | 32 | Return register value |
| sp_i | input | 32 | Stack pointer value |
| ctx_i | input | 32 | Context index |
| addr_o | output | 32 | Registered effective address |
| addr_vld_o | output | 1 | Registered memory-operation strobe |

## Verification
The properties treat every flag and register input as a known 0 or 1 value held steady across a whole cycle, and each per-term property only fires on steps where every other term is switched off and the immediate is zero, so it isolates one contribution. The stimulus changes inputs only on falling edges, never leaves a pin undriven, and mixes isolated single-term steps with combined steps, including the stack-plus-memory overlap, negative immediates and sums that wrap past 2^32.

// File: rtl/seg_addr_pkg.sv
// Shared definitions for the segmented address generator.
// Assumes a single flat address width for all register inputs.
package seg_addr_pkg;
    // Decoded per-step control flags.
    typedef struct packed {
        logic mop;
        logic sel_e0;
        logic sel_ret;
        logic stk;
        logic ctx_en;
        logic mem;
    } step_flags_t;
endpackage

// File: rtl/seg_base_sel.sv
// Base selection stage: starts from zero, the data-register word
// overrides it, and the return register overrides both.
// Assumes the flags are already decoded single bits.
module seg_base_sel #(
    parameter int W = 32
) (
    input  seg_addr_pkg::step_flags_t flags,
    input  logic [W-1:0]              e0,
    input  logic [W-1:0]              ret,
    output logic [W-1:0]              base
);
    // Ordered override: later assignments win.
    always_comb begin
        base = '0;
        if (flags.sel_e0)  base = e0;
        if (flags.sel_ret) base = ret;
    end
endmodule

// File: rtl/seg_region_add.sv
// Adds the enabled terms to the base: signed immediate, stack pointer
// plus stack region, scaled context and memory region. Sums wrap.
// Assumes region constants fit in W bits.
module seg_region_add #(
    parameter int              W         = 32,
    parameter int              IMM_W     = 16,
    parameter logic [W-1:0]    STK_BASE  = 32'h0001_0000,
    parameter logic [W-1:0]    MEM_BASE  = 32'h0002_0000,
    parameter logic [W-1:0]    CTX_SCALE = 32'h0004_0000
) (
    input  seg_addr_pkg::step_flags_t flags,
    input  logic [W-1:0]              base,
    input  logic [IMM_W-1:0]          imm,
    input  logic [W-1:0]              sp,
    input  logic [W-1:0]              ctx,
    output logic [W-1:0]              sum
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;
    logic [W-1:0] ctx_term;

    // Sign-extend the immediate to the address width.
    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Context scaling: a shift when the stride is a power of two.
    generate
        if ((CTX_SCALE & (CTX_SCALE - 1'b1)) == '0) begin : g_ctx_shift
            assign ctx_term = ctx << $clog2(CTX_SCALE);
        end else begin : g_ctx_mul
            assign ctx_term = ctx * CTX_SCALE;
        end
    endgenerate

    // Accumulate the enabled terms in a fixed order.
    always_comb begin
        sum = base;
        if (imm != '0)   sum = sum + imm_ext;
        if (flags.stk)   sum = sum + sp + STK_BASE;
        if (flags.ctx_en) sum = sum + ctx_term;
        if (flags.mem)   sum = sum + MEM_BASE;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top of the segmented address generator. Combines base selection and
// region addition, then registers the address and the memory strobe.
// Assumes inputs are stable for the whole cycle; one step per cycle.
module seg_addr_gen #(
    parameter int           ADDR_W    = 32,
    parameter int           IMM_W     = 16,
    parameter logic [31:0]  STK_BASE  = 32'h0001_0000,
    parameter logic [31:0]  MEM_BASE  = 32'h0002_0000,
    parameter logic [31:0]  CTX_SCALE = 32'h0004_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mop_i,
    input  logic              sel_e0_i,
    input  logic              sel_ret_i,
    input  logic              stk_i,
    input  logic              ctx_en_i,
    input  logic              mem_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] e0_i,
    input  logic [ADDR_W-1:0] ret_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] ctx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);
    import seg_addr_pkg::*;

    localparam logic [ADDR_W-1:0] STK_C = ADDR_W'(STK_BASE);
    localparam logic [ADDR_W-1:0] MEM_C = ADDR_W'(MEM_BASE);
    localparam logic [ADDR_W-1:0] CTX_C = ADDR_W'(CTX_SCALE);

    step_flags_t       flags;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] sum;

    // Pack the flag pins into the shared struct.
    always_comb begin
        flags.mop     = mop_i;
        flags.sel_e0  = sel_e0_i;
        flags.sel_ret = sel_ret_i;
        flags.stk     = stk_i;
        flags.ctx_en  = ctx_en_i;
        flags.mem     = mem_i;
    end

    seg_base_sel #(.W(ADDR_W)) u_base (
        .flags (flags),
        .e0    (e0_i),
        .ret   (ret_i),
        .base  (base)
    );

    seg_region_add #(
        .W(ADDR_W), .IMM_W(IMM_W),
        .STK_BASE(STK_C), .MEM_BASE(MEM_C), .CTX_SCALE(CTX_C)
    ) u_add (
        .flags (flags),
        .base  (base),
        .imm   (imm_i),
        .sp    (sp_i),
        .ctx   (ctx_i),
        .sum   (sum)
    );

    // Output register: address every cycle, strobe from the mop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            addr_vld_o <= 1'b0;
        end else begin
            addr_o     <= sum;
            addr_vld_o <= flags.mop;
        end
    end

    // R2
    vld_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mop_i |=> addr_vld_o);
    // R2
    vld_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mop_i |=> !addr_vld_o);
    // R3
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_e0_i && !sel_ret_i && !stk_i && !ctx_en_i && !mem_i && imm_i == '0)
        |=> addr_o == '0);
    // R5
    ret_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ret_i && !stk_i && !ctx_en_i && !mem_i && imm_i == '0)
        |=> addr_o == $past(ret_i));
    // R4
    e0_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_e0_i && !sel_ret_i && !stk_i && !ctx_en_i && !mem_i && imm_i == '0)
        |=> addr_o == $past(e0_i));
    // R7
    stk_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_i && !sel_e0_i && !sel_ret_i && !ctx_en_i && !mem_i && imm_i == '0)
        |=> addr_o == $past(sp_i) + STK_C);
    // R9
    mem_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_i && !stk_i && !sel_e0_i && !sel_ret_i && !ctx_en_i && imm_i == '0)
        |=> addr_o == MEM_C);
endmodule

// File: tb/tb_seg_addr_gen.sv
// Scoreboard bench: the driver pushes expected results, the monitor
// pops and compares one item per registered output.
module tb_seg_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mop_i, sel_e0_i, sel_ret_i, stk_i, ctx_en_i, mem_i;
    logic [15:0] imm_i;
    logic [31:0] e0_i, ret_i, sp_i, ctx_i;
    logic [31:0] addr_o;
    logic        addr_vld_o;

    typedef struct {
        logic [31:0] addr;
        logic        vld;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .mop_i(mop_i), .sel_e0_i(sel_e0_i),
        .sel_ret_i(sel_ret_i), .stk_i(stk_i), .ctx_en_i(ctx_en_i),
        .mem_i(mem_i), .imm_i(imm_i), .e0_i(e0_i), .ret_i(ret_i),
        .sp_i(sp_i), .ctx_i(ctx_i), .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    // Reference model built from the requirements.
    function automatic logic [31:0] model(input logic f_e0, f_ret, f_stk,
            f_ctx, f_mem, input logic [15:0] imm,
            input logic [31:0] e0, ret, sp, ctx);
        logic [31:0] a;
        a = 32'h0;
        if (f_e0)  a = e0;
        if (f_ret) a = ret;
        a = a + {{16{imm[15]}}, imm};
        if (f_stk) a = a + sp + 32'h0001_0000;
        if (f_ctx) a = a + ctx * 32'h0004_0000;
        if (f_mem) a = a + 32'h0002_0000;
        return a;
    endfunction

    task automatic step(input logic m, f_e0, f_ret, f_stk, f_ctx, f_mem,
            input logic [15:0] imm, input logic [31:0] e0, ret, sp, ctx,
            input string tag);
        exp_t it;
        @(negedge clk);
        mop_i = m; sel_e0_i = f_e0; sel_ret_i = f_ret; stk_i = f_stk;
        ctx_en_i = f_ctx; mem_i = f_mem; imm_i = imm;
        e0_i = e0; ret_i = ret; sp_i = sp; ctx_i = ctx;
        it.addr = model(f_e0, f_ret, f_stk, f_ctx, f_mem, imm, e0, ret, sp, ctx);
        it.vld  = m;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare one queued item after each registered update.
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            total++;
            if (addr_o !== it.addr || addr_vld_o !== it.vld) begin
                bad++;
                $display("FAIL %s: addr=%h vld=%b expected addr=%h vld=%b",
                         it.tag, addr_o, addr_vld_o, it.addr, it.vld);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: cycles=20000 expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        mop_i = 1'b1; sel_e0_i = 1'b1; sel_ret_i = 1'b0; stk_i = 1'b1;
        ctx_en_i = 1'b1; mem_i = 1'b1; imm_i = 16'h0040;
        e0_i = 32'hDEAD_BEEF; ret_i = 32'h1; sp_i = 32'h55; ctx_i = 32'h7;
        repeat (3) @(negedge clk);
        // R1: reset dominates nonzero inputs
        total++;
        if (addr_o !== 32'h0 || addr_vld_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: addr=%h vld=%b expected addr=00000000 vld=0",
                     addr_o, addr_vld_o);
        end
        rst_n = 1'b1;

        step(1, 0, 0, 0, 0, 0, 16'h0000, 32'h1111, 32'h2222, 32'h3, 32'h4, "R3 zero base");
        step(1, 1, 0, 0, 0, 0, 16'h0000, 32'h1234_5678, 32'h2222, 32'h3, 32'h4, "R4 e0 base");
        step(1, 1, 1, 0, 0, 0, 16'h0000, 32'h1234_5678, 32'h0BAD_F00D, 32'h3, 32'h4, "R5 ret over e0");
        step(1, 0, 1, 0, 0, 0, 16'h0000, 32'h0, 32'h0000_0ABC, 32'h3, 32'h4, "R5 ret only");
        step(1, 1, 0, 0, 0, 0, 16'h0100, 32'h0000_1000, 32'h0, 32'h0, 32'h0, "R6 positive imm");
        step(1, 1, 0, 0, 0, 0, 16'hFFF0, 32'h0000_0010, 32'h0, 32'h0, 32'h0, "R6 negative imm");
        step(1, 1, 0, 0, 0, 0, 16'hFFF0, 32'h0000_0005, 32'h0, 32'h0, 32'h0, "R10 imm wraps below zero");
        step(1, 0, 0, 1, 0, 0, 16'h0000, 32'h0, 32'h0, 32'h0000_0020, 32'h0, "R7 stack term");
        step(1, 0, 0, 0, 1, 0, 16'h0000, 32'h0, 32'h0, 32'h0, 32'h0000_0003, "R8 context term");
        step(1, 0, 0, 0, 1, 0, 16'h0000, 32'h0, 32'h0, 32'h0, 32'h0000_4001, "R10 context wraps");
        step(1, 0, 0, 0, 0, 1, 16'h0000, 32'h0, 32'h0, 32'h0, 32'h0, "R9 memory term");
        step(1, 0, 0, 1, 0, 1, 16'h0000, 32'h0, 32'h0, 32'h0000_0001, 32'h0, "R9 stack and memory");
        step(1, 0, 1, 1, 1, 1, 16'h0004, 32'h0, 32'h0000_0100, 32'h0000_0002, 32'h1, "R10 all terms");
        step(0, 1, 0, 0, 0, 0, 16'h0008, 32'h0000_0400, 32'h0, 32'h0, 32'h0, "R2 no mop");
        step(1, 1, 0, 0, 0, 0, 16'h0000, 32'h0000_0400, 32'h0, 32'h0, 32'h0, "R2 mop again");
        step(0, 0, 1, 1, 0, 0, 16'h8000, 32'h0, 32'hFFFF_FFF0, 32'h0000_0100, 32'h0, "R6 R10 min imm wrap");
        step(1, 1, 1, 0, 0, 0, 16'h0000, 32'h1, 32'h2, 32'h0, 32'h0, "R5 back to back");

        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule